// File: doc/BRIEF.md
# Port-Pin Branch Condition Evaluator

This block decides whether a conditional call or a conditional jump is taken. It reads two dedicated port pins and a comparator result. The pins are read at their actual level, whichever direction the pin is driven in, so no direction information enters the block. The first condition always follows pin zero. The second condition follows pin one, unless the comparator enable is set, in which case it follows the comparator output.

Each branch request arrives as a one-cycle strobe with a 3-bit opcode class:

| Bit | Meaning |
|-----|---------|
| 0 | Call or jump |
| 1 | Inverted sense |
| 2 | Selects condition 2 |

The pins and the comparator output are asynchronous. They pass through a two-flop synchronizer before they are evaluated. The verdict is registered by a two-state controller:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No verdict is presented; take is low. |
| `ST_REPORT` | The registered verdict drives take for one cycle. |

The controller has three transitions:

| Transition | From | To | When |
|------------|------|----|------|
| `accept` | `ST_IDLE` | `ST_REPORT` | A strobe is present. |
| `chain` | `ST_REPORT` | `ST_REPORT` | A strobe is present. |
| `retire` | `ST_REPORT` | `ST_IDLE` | No strobe is present. |

The two resolved condition flags are also brought out, for observation by the sequencer.

Top module: `port_branch_eval`

## Requirements
- R1: `cond1_o` equals the level of `pin_d0_i` that was present two clock edges earlier (two-flop synchronizer).
- R2: When `cmp_en_i` is 0, `cond2_o` equals the level of `pin_d1_i` that was present two edges earlier.
- R3: When `cmp_en_i` is 1, `cond2_o` equals `cmp_out_i` as it was two edges earlier, and `pin_d1_i` has no effect on `cond2_o` or on the verdict.
- R4: A true-sense request (`op_class_i[1]`=0) is taken (`take_o`=1) when its selected condition is 1. It is ignored (`take_o`=0) when the condition is 0. `op_class_i[2]`=0 selects condition 1; `op_class_i[2]`=1 selects condition 2.
- R5: An inverted-sense request (`op_class_i[1]`=1) is taken when its selected condition is 0 and ignored when it is 1.
- R6: The call/jump bit `op_class_i[0]` (0 = call, 1 = jump) does not change the verdict.
- R7: `take_o` is registered. It shows the verdict in the cycle that follows the edge that samples `op_valid_i`=1, and for exactly one cycle per strobe. Back-to-back strobes give back-to-back verdicts.
- R8: If `op_valid_i` was 0 at the previous edge, `take_o` is 0.
- R9: While reset is active, and after it, `take_o`, `cond1_o` and `cond2_o` are 0 until new pin levels have propagated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_d0_i | input | 1 | Level of port pin zero |
| pin_d1_i | input | 1 | Level of port pin one |
| cmp_en_i | input | 1 | Comparator enable; 1 routes the comparator to condition 2 |
| cmp_out_i | input | 1 | Comparator result |
| op_valid_i | input | 1 | One-cycle strobe marking a conditional branch request |
| op_class_i | input | 3 | Opcode class: bit0 call/jump, bit1 inverted, bit2 condition 2 |
| take_o | output | 1 | Registered branch-taken verdict |
| cond1_o | output | 1 | Resolved condition 1 |
| cond2_o | output | 1 | Resolved condition 2 |

## Verification
The condition flags settle two edges after a pin or comparator change. The bench therefore changes those inputs at a falling edge and waits three falling edges before it reads the flags or issues a request.

`take_o` is due in the cycle after the edge that samples the strobe. Each request task raises the strobe at a falling edge, drops it at the next falling edge, and reads `take_o` at once. It then reads `take_o` again one cycle later to confirm the pulse ended. The back-to-back case reads one verdict per cycle on successive falling edges.

// File: rtl/port_branch_pkg.sv
package port_branch_pkg;

    localparam int OP_W = 3;

    typedef struct packed {
        logic use_cond2;
        logic invert;
        logic is_jump;
    } br_op_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } dec_state_t;

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pb_resolve.sv
module pb_resolve
    import port_branch_pkg::*;
(
    input  logic   d0_i,
    input  logic   d1_i,
    input  logic   cmp_i,
    input  logic   cmp_en_i,
    input  br_op_t op_i,
    output logic   cond1_o,
    output logic   cond2_o,
    output logic   verdict_o
);

    logic picked;

    always_comb begin
        cond1_o   = d0_i;
        cond2_o   = cmp_en_i ? cmp_i : d1_i;
        picked    = op_i.use_cond2 ? cond2_o : cond1_o;
        verdict_o = picked ^ op_i.invert;
    end

endmodule

// File: rtl/pb_decide.sv
module pb_decide
    import port_branch_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic valid_i,
    input  logic verdict_i,
    output logic take_o
);

    dec_state_t state_q, state_d;
    logic       verdict_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (valid_i) state_d = ST_REPORT;
            ST_REPORT: state_d = valid_i ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            verdict_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (valid_i) verdict_q <= verdict_i;
        end
    end

    always_comb begin
        take_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   take_o = 1'b0;
            ST_REPORT: take_o = verdict_q;
            default:   take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/port_branch_eval.sv
module port_branch_eval
    import port_branch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            pin_d0_i,
    input  logic            pin_d1_i,
    input  logic            cmp_en_i,
    input  logic            cmp_out_i,
    input  logic            op_valid_i,
    input  logic [OP_W-1:0] op_class_i,
    output logic            take_o,
    output logic            cond1_o,
    output logic            cond2_o
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              verdict;
    br_op_t            op;

    assign raw_in = {cmp_out_i, pin_d1_i, pin_d0_i};
    assign op     = br_op_t'(op_class_i);

    pb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_in),
        .q_o    (sync_out)
    );

    pb_resolve resolve_i (
        .d0_i      (sync_out[0]),
        .d1_i      (sync_out[1]),
        .cmp_i     (sync_out[2]),
        .cmp_en_i  (cmp_en_i),
        .op_i      (op),
        .cond1_o   (cond1_o),
        .cond2_o   (cond2_o),
        .verdict_o (verdict)
    );

    pb_decide decide_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .valid_i   (op_valid_i),
        .verdict_i (verdict),
        .take_o    (take_o)
    );

endmodule

// File: rtl/port_branch_eval_chk.sv
module port_branch_eval_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pin_d0_i,
    input logic       pin_d1_i,
    input logic       cmp_en_i,
    input logic       cmp_out_i,
    input logic       op_valid_i,
    input logic [2:0] op_class_i,
    input logic       take_o,
    input logic       cond1_o,
    input logic       cond2_o
);

    logic [1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    cond1_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (cond1_o == $past(pin_d0_i, 2)));

    // R2
    cond2_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2 && !cmp_en_i) |-> (cond2_o == $past(pin_d1_i, 2)));

    // R3
    cond2_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2 && cmp_en_i) |-> (cond2_o == $past(cmp_out_i, 2)));

    // R8
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd1 && !$past(op_valid_i)) |-> !take_o);

    // R4
    true_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd1 && $past(op_valid_i) && !$past(op_class_i[1]))
        |-> (take_o == $past(op_class_i[2] ? cond2_o : cond1_o)));

    // R5
    inv_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd1 && $past(op_valid_i) && $past(op_class_i[1]))
        |-> (take_o == !$past(op_class_i[2] ? cond2_o : cond1_o)));

    // R9
    always_comb begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (!take_o && !cond1_o && !cond2_o);
        end
    end

endmodule

bind port_branch_eval port_branch_eval_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_d0_i   (pin_d0_i),
    .pin_d1_i   (pin_d1_i),
    .cmp_en_i   (cmp_en_i),
    .cmp_out_i  (cmp_out_i),
    .op_valid_i (op_valid_i),
    .op_class_i (op_class_i),
    .take_o     (take_o),
    .cond1_o    (cond1_o),
    .cond2_o    (cond2_o)
);

// File: tb/port_branch_eval_tb_top.sv
`timescale 1ns/1ps
module port_branch_eval_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       d0 = 1'b0, d1 = 1'b0, cen = 1'b0, cmp = 1'b0;
    logic       vld = 1'b0;
    logic [2:0] cls = 3'b000;
    logic       take, c1, c2;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    port_branch_eval dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pin_d0_i(d0), .pin_d1_i(d1),
        .cmp_en_i(cen), .cmp_out_i(cmp), .op_valid_i(vld), .op_class_i(cls),
        .take_o(take), .cond1_o(c1), .cond2_o(c2)
    );

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic set_inputs(logic p0, logic p1, logic en, logic cm);
        @(negedge clk);
        d0 = p0; d1 = p1; cen = en; cmp = cm;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic model(logic [2:0] c, logic p0, logic p1, logic en, logic cm);
        logic sel;
        sel = c[2] ? (en ? cm : p1) : p0;
        return sel ^ c[1];
    endfunction

    task automatic request(string req, logic [2:0] c);
        logic exp;
        exp = model(c, d0, d1, cen, cmp);
        vld = 1'b1; cls = c;
        @(negedge clk);
        vld = 1'b0; cls = 3'b000;
        check(req, take, exp);
        @(negedge clk);
        check("R7", take, 1'b0);
    endtask

    task automatic t_reset();
        check("R9", take, 1'b0);
        check("R9", c1, 1'b0);
        check("R9", c2, 1'b0);
    endtask

    task automatic t_cond1();
        set_inputs(1, 0, 0, 0);
        check("R1", c1, 1'b1);
        request("R4", 3'b000);
        request("R5", 3'b010);
        set_inputs(0, 0, 0, 0);
        check("R1", c1, 1'b0);
        request("R4", 3'b001);
        request("R5", 3'b011);
    endtask

    task automatic t_cond2_pin();
        set_inputs(0, 1, 0, 0);
        check("R2", c2, 1'b1);
        request("R4", 3'b100);
        request("R5", 3'b110);
        set_inputs(1, 0, 0, 1);
        check("R2", c2, 1'b0);
        request("R4", 3'b101);
        request("R5", 3'b111);
    endtask

    task automatic t_comparator();
        set_inputs(0, 0, 1, 1);
        check("R3", c2, 1'b1);
        request("R3", 3'b100);
        set_inputs(0, 1, 1, 0);
        check("R3", c2, 1'b0);
        request("R3", 3'b100);
        request("R3", 3'b110);
    endtask

    task automatic t_call_jump();
        set_inputs(1, 1, 0, 0);
        request("R6", 3'b000);
        request("R6", 3'b001);
        request("R6", 3'b110);
        request("R6", 3'b111);
    endtask

    task automatic t_idle();
        set_inputs(1, 1, 0, 0);
        repeat (4) begin
            @(negedge clk);
            check("R8", take, 1'b0);
        end
    endtask

    task automatic t_back_to_back();
        set_inputs(1, 0, 0, 0);
        vld = 1'b1; cls = 3'b000;
        @(negedge clk);
        check("R7", take, 1'b1);
        cls = 3'b010;
        @(negedge clk);
        check("R7", take, 1'b0);
        cls = 3'b110;
        @(negedge clk);
        vld = 1'b0; cls = 3'b000;
        check("R7", take, 1'b1);
        @(negedge clk);
        check("R7", take, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cond1();
        t_cond2_pin();
        t_comparator();
        t_call_jump();
        t_idle();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule